// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

This block watches 24 input lines and turns selected signal edges into interrupt requests and single-cycle event pulses. Software chooses, for each line, whether a rising edge, a falling edge or both count as a trigger. Two separate masks then route a trigger to the interrupt path, the event path, or both. The interrupt path sets a sticky pending bit. The event path emits a pulse exactly one bus clock wide and leaves the pending bit alone.

Each line first passes through an edge capture stage that registers on the line itself. A pulse narrower than one bus clock period is therefore still seen. The captured edges cross into the bus clock domain through a two-stage synchronizer. A software trigger register lets firmware fire a line without any external activity.

Software talks to the block over a simple APB-style register port with no wait states. There are six 32-bit registers, and only bits 23:0 are implemented. Interrupt requests go to a downstream interrupt controller. Event pulses go to wake-up logic.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00000000, and irq_o and evt_o are all zero.
- R2: The registers sit at these byte offsets: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. Line n is bit n. Bits 31:24 always read as zero. The four configuration registers read back what was written.
- R3: When line n has its rising select bit set and its interrupt mask bit set, a rising edge sets pending bit n. This is visible on the third rising clock edge after the line changes. irq_o[n] then goes high.
- R4: A falling edge triggers only when the falling select bit is set. With both select bits set, either edge triggers. With neither set, a line's edges set nothing.
- R5: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R6: When the event mask bit for line n is set, a selected edge produces evt_o[n] high for exactly one clock cycle. An edge on a line whose interrupt mask bit is clear never sets that line's pending bit.
- R7: Writing 1 to a software trigger bit that reads 0 does two things in the write cycle: it sets the matching pending bit if the line's interrupt mask bit is set, and it pulses evt_o if the line's event mask bit is set. The software trigger bit then reads 1 until the matching pending bit is cleared by a write of 1. Writing 1 again while it reads 1 fires nothing.
- R8: A pulse on a line that is shorter than one clock period, and that falls between clock edges, is still detected as a rising edge and as a falling edge.
- R9: If a rising edge reaches the trigger logic in the same cycle as a write that enables rising select for that line, the pending bit is set. If a falling edge reaches it in the same cycle as any write to the falling select register, it is ignored.
- R10: Writes to unmapped offsets change no register and no pending bit.
- R11: If a trigger and a write-1 clear hit the same pending bit in the same cycle, the bit stays set.
- R12: irq_o[n] equals pending bit n ANDed with interrupt mask bit n. Clearing the mask drops the request, but the pending bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while the address is held |
| line_in | input | 24 | Trigger lines, may be asynchronous |
| irq_o | output | 24 | Per-line interrupt request, level |
| evt_o | output | 24 | Per-line event pulse, one cycle |

## Verification
The assertions assume register accesses follow a setup phase followed by one access phase. They also assume that the software trigger register and the pending register are never written in the same cycle. The port makes that second case impossible, because an access carries a single address. Line inputs are taken as free-running and unconstrained, but each assertion reasons only about synchronized edges.

The bench therefore changes lines only at falling clock edges, or as short pulses placed entirely between rising edges. It also places the race cases so that the synchronized edge lands exactly in the access-phase cycle of the conflicting write.

// File: rtl/eic_pkg.sv
// Shared constants for the edge-triggered interrupt/event controller.
// Assumes byte addressing with 32-bit registers on 4-byte boundaries.
package eic_pkg;
    localparam int unsigned OFF_IMASK = 'h00;
    localparam int unsigned OFF_EMASK = 'h04;
    localparam int unsigned OFF_RISE  = 'h08;
    localparam int unsigned OFF_FALL  = 'h0C;
    localparam int unsigned OFF_SWTRG = 'h10;
    localparam int unsigned OFF_PEND  = 'h14;
endpackage

// File: rtl/eic_edge_sync.sv
// Per-line edge capture and clock-domain crossing.
// Each line drives two toggle flops, one clocked by its rising edge and one by
// its falling edge, so pulses shorter than a bus clock period are not lost.
// The toggles cross into clk through SYNC_N flops. A change in the synchronized
// toggle marks one edge for one clk cycle.
// Assumes that two edges of the same polarity on one line are at least
// SYNC_N+1 clk cycles apart; closer edges merge or cancel.
module eic_edge_sync #(
    parameter int unsigned N_LINES = 24,
    parameter int unsigned SYNC_N  = 2
) (
    input  logic               clk,
    input  logic [N_LINES-1:0] line_in,
    output logic [N_LINES-1:0] rise_seen,
    output logic [N_LINES-1:0] fall_seen
);
    localparam int unsigned SH_TOP = SYNC_N - 1;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic              r_tog;
        logic              f_tog;
        logic [SH_TOP:0]   r_sh;
        logic [SH_TOP:0]   f_sh;
        logic              r_prev;
        logic              f_prev;

        // flips once per rising edge of the line, independent of clk
        always_ff @(posedge line_in[g]) begin
            r_tog <= ~r_tog;
        end

        // flips once per falling edge of the line, independent of clk
        always_ff @(negedge line_in[g]) begin
            f_tog <= ~f_tog;
        end

        // synchronizer chains and last-seen copies; no reset needed because
        // only changes of the toggles are meaningful
        always_ff @(posedge clk) begin
            r_sh   <= {r_sh[SH_TOP-1:0], r_tog};
            f_sh   <= {f_sh[SH_TOP-1:0], f_tog};
            r_prev <= r_sh[SH_TOP];
            f_prev <= f_sh[SH_TOP];
        end

        assign rise_seen[g] = r_sh[SH_TOP] ^ r_prev;
        assign fall_seen[g] = f_sh[SH_TOP] ^ f_prev;
    end
endmodule

// File: rtl/eic_regs.sv
// Register bank and decode for the controller: the four configuration
// registers, per-register write strobes and the read mux.
// Assumes a zero-wait-state access; a write commits on the clk edge that ends
// the access phase (psel & penable & pwrite). Reserved bits read as zero.
module eic_regs #(
    parameter int unsigned N_LINES = 24,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    input  logic [N_LINES-1:0] pend,
    input  logic [N_LINES-1:0] swtrg,
    output logic [N_LINES-1:0] imask,
    output logic [N_LINES-1:0] emask,
    output logic [N_LINES-1:0] rise_sel,
    output logic [N_LINES-1:0] fall_sel,
    output logic               wr_rise,
    output logic               wr_fall,
    output logic               wr_swtrg,
    output logic               wr_pend,
    output logic [N_LINES-1:0] wr_lines,
    output logic [DATA_W-1:0]  prdata
);
    import eic_pkg::*;

    localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(OFF_IMASK);
    localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(OFF_EMASK);
    localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(OFF_RISE);
    localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(OFF_FALL);
    localparam logic [ADDR_W-1:0] A_SWTRG = ADDR_W'(OFF_SWTRG);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);

    logic wr_acc;
    logic wr_imask;
    logic wr_emask;
    logic unused_wdata_hi;

    assign wr_acc   = psel & penable & pwrite;
    assign wr_imask = wr_acc && (paddr == A_IMASK);
    assign wr_emask = wr_acc && (paddr == A_EMASK);
    assign wr_rise  = wr_acc && (paddr == A_RISE);
    assign wr_fall  = wr_acc && (paddr == A_FALL);
    assign wr_swtrg = wr_acc && (paddr == A_SWTRG);
    assign wr_pend  = wr_acc && (paddr == A_PEND);
    assign wr_lines = pwdata[N_LINES-1:0];
    assign unused_wdata_hi = ^pwdata[DATA_W-1:N_LINES];

    // configuration registers, each loaded only by its own offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask    <= '0;
            emask    <= '0;
            rise_sel <= '0;
            fall_sel <= '0;
        end else begin
            if (wr_imask) imask    <= wr_lines;
            if (wr_emask) emask    <= wr_lines;
            if (wr_rise)  rise_sel <= wr_lines;
            if (wr_fall)  fall_sel <= wr_lines;
        end
    end

    // read mux, zero-extended lines, zero for unmapped offsets
    always_comb begin
        case (paddr)
            A_IMASK: prdata = DATA_W'(imask);
            A_EMASK: prdata = DATA_W'(emask);
            A_RISE:  prdata = DATA_W'(rise_sel);
            A_FALL:  prdata = DATA_W'(fall_sel);
            A_SWTRG: prdata = DATA_W'(swtrg);
            A_PEND:  prdata = DATA_W'(pend);
            default: prdata = '0;
        endcase
    end

    AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && paddr != A_IMASK && paddr != A_EMASK && paddr != A_RISE &&
         paddr != A_FALL && paddr != A_SWTRG && paddr != A_PEND)
        |=> ($stable(imask) && $stable(emask) && $stable(rise_sel) && $stable(fall_sel))); // R10
endmodule

// File: rtl/eic_pend.sv
// Trigger qualification, pending bits, software trigger bits and event pulses.
// A trigger sets a pending bit only on lines with the interrupt mask set; set
// wins over a write-1 clear in the same cycle. Events are registered, one
// cycle wide, and never touch pending bits.
// Assumes the software trigger and pending registers are not written in the
// same cycle (one address per access).
module eic_pend #(
    parameter int unsigned N_LINES = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] rise_seen,
    input  logic [N_LINES-1:0] fall_seen,
    input  logic [N_LINES-1:0] imask,
    input  logic [N_LINES-1:0] emask,
    input  logic [N_LINES-1:0] rise_sel,
    input  logic [N_LINES-1:0] fall_sel,
    input  logic               wr_rise,
    input  logic               wr_fall,
    input  logic               wr_swtrg,
    input  logic               wr_pend,
    input  logic [N_LINES-1:0] wr_lines,
    output logic [N_LINES-1:0] pend,
    output logic [N_LINES-1:0] swtrg,
    output logic [N_LINES-1:0] irq_o,
    output logic [N_LINES-1:0] evt_o
);
    logic [N_LINES-1:0] rise_en;
    logic [N_LINES-1:0] fall_en;
    logic [N_LINES-1:0] hw_trig;
    logic [N_LINES-1:0] sw_fire;
    logic [N_LINES-1:0] clr;
    logic [N_LINES-1:0] pset;

    // effective edge enables: a rising-select write opens its lines at once,
    // a falling-select write blanks falling triggers for that cycle
    always_comb begin
        rise_en = wr_rise ? (rise_sel | wr_lines) : rise_sel;
        fall_en = wr_fall ? '0 : fall_sel;
        hw_trig = (rise_seen & rise_en) | (fall_seen & fall_en);
        sw_fire = wr_swtrg ? (wr_lines & ~swtrg) : '0;
        clr     = wr_pend ? wr_lines : '0;
        pset    = (hw_trig | sw_fire) & imask;
    end

    // pending and software trigger state, event pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            swtrg <= '0;
            evt_o <= '0;
        end else begin
            pend  <= (pend & ~clr) | pset;
            swtrg <= (swtrg | (wr_swtrg ? wr_lines : '0)) & ~clr;
            evt_o <= (hw_trig | sw_fire) & emask;
        end
    end

    assign irq_o = pend & imask;

    AST_PEND_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~pend & ~$past(clr)) == '0)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pset != '0) |=> ((~pend & $past(pset)) == '0)); // R11
    AST_PEND_NEEDS_IMASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(imask)) == '0)); // R6
    AST_EVT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & ~$past(emask)) == '0)); // R6
    AST_SWTRG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((swtrg & $past(clr)) == '0)); // R7
endmodule

// File: rtl/edge_irq_ctrl.sv
// Top of the edge-triggered interrupt/event controller: edge capture and
// synchronization, register bank, and pending/event logic.
// Assumes clk is the bus clock and line_in may be fully asynchronous.
module edge_irq_ctrl #(
    parameter int unsigned N_LINES = 24,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SYNC_N  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    input  logic [N_LINES-1:0] line_in,
    output logic [N_LINES-1:0] irq_o,
    output logic [N_LINES-1:0] evt_o
);
    logic [N_LINES-1:0] rise_seen;
    logic [N_LINES-1:0] fall_seen;
    logic [N_LINES-1:0] imask;
    logic [N_LINES-1:0] emask;
    logic [N_LINES-1:0] rise_sel;
    logic [N_LINES-1:0] fall_sel;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] swtrg;
    logic [N_LINES-1:0] wr_lines;
    logic               wr_rise;
    logic               wr_fall;
    logic               wr_swtrg;
    logic               wr_pend;

    eic_edge_sync #(.N_LINES(N_LINES), .SYNC_N(SYNC_N)) u_sync (
        .clk       (clk),
        .line_in   (line_in),
        .rise_seen (rise_seen),
        .fall_seen (fall_seen)
    );

    eic_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .pend     (pend),
        .swtrg    (swtrg),
        .imask    (imask),
        .emask    (emask),
        .rise_sel (rise_sel),
        .fall_sel (fall_sel),
        .wr_rise  (wr_rise),
        .wr_fall  (wr_fall),
        .wr_swtrg (wr_swtrg),
        .wr_pend  (wr_pend),
        .wr_lines (wr_lines),
        .prdata   (prdata)
    );

    eic_pend #(.N_LINES(N_LINES)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_seen (rise_seen),
        .fall_seen (fall_seen),
        .imask     (imask),
        .emask     (emask),
        .rise_sel  (rise_sel),
        .fall_sel  (fall_sel),
        .wr_rise   (wr_rise),
        .wr_fall   (wr_fall),
        .wr_swtrg  (wr_swtrg),
        .wr_pend   (wr_pend),
        .wr_lines  (wr_lines),
        .pend      (pend),
        .swtrg     (swtrg),
        .irq_o     (irq_o),
        .evt_o     (evt_o)
    );

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~imask) == '0 && (irq_o & ~pend) == '0)); // R12
endmodule

// File: tb/sim_edge_irq_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_edge_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_IM = 8'h00, A_EM = 8'h04, A_RS = 8'h08,
                           A_FS = 8'h0C, A_SW = 8'h10, A_PR = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [23:0] line_in = '0;
    logic [23:0] irq_o;
    logic [23:0] evt_o;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .line_in(line_in), .irq_o(irq_o), .evt_o(evt_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // setup at a negedge, access phase at the next, commit at the posedge between
    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_rd(a, d);
        check(tag, d, exp);
    endtask

    // wait until a line change made at the current negedge is reflected
    task automatic wait_sync();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clean();
        apb_wr(A_IM, 0); apb_wr(A_EM, 0); apb_wr(A_RS, 0); apb_wr(A_FS, 0);
        apb_wr(A_PR, 32'h00FF_FFFF);
        line_in = '0;
        wait_sync();
    endtask

    task automatic t_reset();
        rd_chk("R1 imask reset", A_IM, 0);
        rd_chk("R1 emask reset", A_EM, 0);
        rd_chk("R1 rise reset", A_RS, 0);
        rd_chk("R1 fall reset", A_FS, 0);
        rd_chk("R1 swtrg reset", A_SW, 0);
        rd_chk("R1 pend reset", A_PR, 0);
        check("R1 irq reset", 32'(irq_o), 0);
        check("R1 evt reset", 32'(evt_o), 0);
    endtask

    task automatic t_map();
        apb_wr(A_IM, 32'hFFFF_FFFF);
        rd_chk("R2 reserved bits zero", A_IM, 32'h00FF_FFFF);
        apb_wr(A_IM, 32'h0012_3456);
        apb_wr(A_EM, 32'h00A5_A5A5);
        apb_wr(A_RS, 32'h0055_AA00);
        apb_wr(A_FS, 32'h0000_F00F);
        rd_chk("R2 imask offset", A_IM, 32'h0012_3456);
        rd_chk("R2 emask offset", A_EM, 32'h00A5_A5A5);
        rd_chk("R2 rise offset", A_RS, 32'h0055_AA00);
        rd_chk("R2 fall offset", A_FS, 32'h0000_F00F);
        clean();
    endtask

    task automatic t_rise();
        apb_wr(A_RS, 32'h1); apb_wr(A_IM, 32'h1);
        line_in[0] = 1;
        repeat (2) @(posedge clk); @(negedge clk);
        check("R3 not yet after two edges", 32'(irq_o), 0);
        @(posedge clk); @(negedge clk);
        check("R3 irq after rise", 32'(irq_o), 32'h1);
        rd_chk("R3 pending after rise", A_PR, 32'h1);
        line_in[0] = 0; wait_sync();
        rd_chk("R4 fall ignored without select", A_PR, 32'h1);
        // R5: write 0 has no effect, write 1 clears
        apb_wr(A_PR, 32'h0);
        rd_chk("R5 write zero keeps pending", A_PR, 32'h1);
        apb_wr(A_PR, 32'h1);
        rd_chk("R5 write one clears", A_PR, 32'h0);
        check("R5 irq dropped", 32'(irq_o), 0);
        clean();
    endtask

    task automatic t_fall_both();
        apb_wr(A_FS, 32'h8); apb_wr(A_IM, 32'h28);
        line_in[3] = 1; wait_sync();
        rd_chk("R4 rise ignored with fall only", A_PR, 0);
        line_in[3] = 0; wait_sync();
        rd_chk("R4 fall sets pending", A_PR, 32'h8);
        apb_wr(A_PR, 32'h8);
        apb_wr(A_RS, 32'h8);
        line_in[3] = 1; wait_sync();
        rd_chk("R4 both: rise triggers", A_PR, 32'h8);
        apb_wr(A_PR, 32'h8);
        line_in[3] = 0; wait_sync();
        rd_chk("R4 both: fall triggers", A_PR, 32'h8);
        line_in[5] = 1; wait_sync(); line_in[5] = 0; wait_sync();
        rd_chk("R4 no select on line 5", A_PR, 32'h8);
        clean();
    endtask

    task automatic t_event();
        apb_wr(A_EM, 32'h20); apb_wr(A_RS, 32'h20);
        line_in[5] = 1; wait_sync();
        check("R6 event pulse high", 32'(evt_o), 32'h20);
        @(negedge clk);
        check("R6 event one cycle", 32'(evt_o), 0);
        rd_chk("R6 event without imask leaves pending", A_PR, 0);
        clean();
    endtask

    task automatic t_mask();
        apb_wr(A_RS, 32'h1); apb_wr(A_IM, 32'h1);
        line_in[0] = 1; wait_sync();
        apb_wr(A_IM, 32'h0);
        check("R12 irq masked", 32'(irq_o), 0);
        rd_chk("R12 pending kept", A_PR, 32'h1);
        apb_wr(A_IM, 32'h1);
        check("R12 irq back", 32'(irq_o), 32'h1);
        clean();
    endtask

    task automatic t_soft();
        apb_wr(A_IM, 32'h80); apb_wr(A_EM, 32'h80);
        apb_wr(A_SW, 32'h80);
        check("R7 sw event pulse", 32'(evt_o), 32'h80);
        @(negedge clk);
        check("R7 sw event one cycle", 32'(evt_o), 0);
        rd_chk("R7 sw sets pending", A_PR, 32'h80);
        rd_chk("R7 sw bit reads one", A_SW, 32'h80);
        apb_wr(A_SW, 32'h80);
        check("R7 repeat write no event", 32'(evt_o), 0);
        apb_wr(A_PR, 32'h80);
        rd_chk("R7 sw bit cleared with pending", A_SW, 0);
        rd_chk("R7 pending cleared", A_PR, 0);
        clean();
    endtask

    task automatic t_short();
        apb_wr(A_RS, 32'h200); apb_wr(A_FS, 32'h400); apb_wr(A_IM, 32'h600);
        @(negedge clk); #1 line_in[9] = 1; #2 line_in[9] = 0;
        wait_sync();
        rd_chk("R8 short pulse rise detected", A_PR, 32'h200);
        @(negedge clk); #1 line_in[10] = 1; #2 line_in[10] = 0;
        wait_sync();
        rd_chk("R8 short pulse fall detected", A_PR, 32'h600);
        clean();
    endtask

    task automatic t_race();
        apb_wr(A_IM, 32'h1800);
        line_in[11] = 1;          // synced edge lands in the access phase
        apb_wr(A_RS, 32'h800);
        rd_chk("R9 rise during rise-select write", A_PR, 32'h800);
        apb_wr(A_FS, 32'h1000);
        line_in[12] = 1; wait_sync();
        line_in[12] = 0;
        apb_wr(A_FS, 32'h1000);
        wait_sync();
        rd_chk("R9 fall during fall-select write ignored", A_PR, 32'h800);
        line_in[12] = 1; wait_sync(); line_in[12] = 0; wait_sync();
        rd_chk("R9 fall select active afterwards", A_PR, 32'h1800);
        clean();
    endtask

    task automatic t_prio();
        apb_wr(A_RS, 32'h2000); apb_wr(A_IM, 32'h2000);
        line_in[13] = 1; wait_sync(); line_in[13] = 0; wait_sync();
        line_in[13] = 1;
        apb_wr(A_PR, 32'h2000);
        rd_chk("R11 set wins over clear", A_PR, 32'h2000);
        apb_wr(A_PR, 32'h2000);
        rd_chk("R11 plain clear", A_PR, 0);
        clean();
    endtask

    task automatic t_unmapped();
        apb_wr(A_IM, 32'h4); apb_wr(A_SW, 32'h4);
        apb_wr(8'h18, 32'hFFFF_FFFF);
        apb_wr(8'h40, 32'hFFFF_FFFF);
        apb_wr(8'h16, 32'hFFFF_FFFF);
        rd_chk("R10 imask unchanged", A_IM, 32'h4);
        rd_chk("R10 emask unchanged", A_EM, 0);
        rd_chk("R10 rise unchanged", A_RS, 0);
        rd_chk("R10 fall unchanged", A_FS, 0);
        rd_chk("R10 pending unchanged", A_PR, 32'h4);
        rd_chk("R10 unmapped reads zero", 8'h18, 0);
        clean();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_map();
        t_rise();
        t_fall_both();
        t_event();
        t_mask();
        t_soft();
        t_short();
        t_race();
        t_prio();
        t_unmapped();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1-R12 run: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule